// File: doc/BRIEF.md
# Per-Pin GPIO Bank with Edge and Level Interrupts

This block is a bank of general-purpose I/O pins. Every pin owns one 32-bit control and status word, reached through a flat register port with an address, a write strobe, write data and combinational read data. Each word sets the pin's output level and its drive behaviour. It also controls whether the input stage is open and which interrupt condition is watched. The word reports the measured input level and a sticky interrupt flag.

The drive enable is split by output level: one bit enables the driver while the output is low, another while it is high. With one of the two cleared, a pin acts as an open-drain or an open-source line. Pad inputs pass through a synchronizer before any use. An interrupt mode picks rising, falling or either edge, which latch a flag cleared by writing one. It can instead pick a low or high level, which feeds the synchronized pin state straight to the interrupt output. A read-only summary word gathers the gated input levels of the first 32 pins. The bank drives a per-pin interrupt vector and one combined line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin word reads 0x0000_0001 (output level 1, every other field 0), the summary word at address NUM_PINS reads 0, and no pad is driven.
- R2: Pin i's word sits at address i. Bit 0 is the output level, bit 1 the measured input (read-only), bit 4 the low-drive enable, bit 5 the high-drive enable, bit 6 the input enable, bits 26:24 the interrupt mode, bit 27 the interrupt flag and bit 31 the pin enable. All other bits read 0. Addresses above NUM_PINS read 0, and writes to the summary word are ignored.
- R3: pad_out carries the output level. pad_oe is 1 only when the pin is enabled and either the output level is 0 with the low-drive enable set, or the output level is 1 with the high-drive enable set.
- R4: Bit 1 of a pin word equals the pad level two clock edges after the pad changes, but only while both the input enable and the pin enable are set; otherwise it reads 0.
- R5: Bit i of the summary word equals bit 1 of pin i's word, for pins 0 to 31.
- R6: In modes 1 (rising), 2 (falling) and 3 (either edge), the flag sets on the third clock edge after the matching pad change and stays set. Writing 1 to bit 27 clears it, and writing 0 leaves it set. pin_irq follows the flag.
- R7: In mode 4 pin_irq is the inverse of the synchronized pad level, and in mode 5 it is the synchronized pad level. Both are due two edges after the pad change, and the flag is not set.
- R8: Modes 0, 6 and 7 raise no interrupt.
- R9: While the pin enable is 0, the pad is not driven, the input bit reads 0, pin_irq is 0, and no edge sets the flag.
- R10: irq is the OR of all bits of pin_irq.
- R11: When an edge sets the flag in the same cycle that software writes 1 to bit 27, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address: pins at 0..NUM_PINS-1, summary at NUM_PINS |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Level to drive on each pad |
| pad_oe | output | NUM_PINS | Per-pad output driver enable |
| pin_irq | output | NUM_PINS | Per-pin interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the next edge, and read data and pad drive follow combinationally. A pad change appears in the input bit and the level interrupts after two edges, and in the edge flag after three. The bench drives every input just after a falling edge and lets one rising edge pass. It advances a cycle model that holds the same two-stage pipeline and samples all outputs at the following falling edge. Directed sequences assert the exact edge counts by checking one step before and one step at the due cycle, including the same-cycle set and clear.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned B_OUT    = 0;
   localparam int unsigned B_IN     = 1;
   localparam int unsigned B_LO_EN  = 4;
   localparam int unsigned B_HI_EN  = 5;
   localparam int unsigned B_IN_EN  = 6;
   localparam int unsigned B_MODE_L = 24;
   localparam int unsigned B_MODE_H = 26;
   localparam int unsigned B_FLAG   = 27;
   localparam int unsigned B_PIN_EN = 31;

   typedef enum logic [2:0] {
      TRIG_NONE = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_FALL = 3'd2,
      TRIG_BOTH = 3'd3,
      TRIG_LOW  = 3'd4,
      TRIG_HIGH = 3'd5,
      TRIG_RSV6 = 3'd6,
      TRIG_RSV7 = 3'd7
   } trig_mode_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin.sv
`timescale 1ns/1ps
module gpio_pin
   import gpio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wdata,
   input  logic              lvl,
   output logic [WORD_W-1:0] word,
   output logic              in_value,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              irq
);
   logic       out_val, lo_en, hi_en, in_en, pin_en, flag, prev;
   trig_mode_e mode;
   logic       rise, fall, edge_hit, edge_mode, level_hit, clr;

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
   assign clr  = wr_sel & wdata[B_FLAG];

   always_comb begin
      edge_hit  = 1'b0;
      level_hit = 1'b0;
      edge_mode = 1'b0;
      unique case (mode)
         TRIG_RISE: begin edge_mode = 1'b1; edge_hit = rise;        end
         TRIG_FALL: begin edge_mode = 1'b1; edge_hit = fall;        end
         TRIG_BOTH: begin edge_mode = 1'b1; edge_hit = rise | fall; end
         TRIG_LOW:  level_hit = ~lvl;
         TRIG_HIGH: level_hit = lvl;
         default:   ;
      endcase
      edge_hit = edge_hit & pin_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_val <= 1'b1;
         lo_en   <= 1'b0;
         hi_en   <= 1'b0;
         in_en   <= 1'b0;
         pin_en  <= 1'b0;
         mode    <= TRIG_NONE;
         flag    <= 1'b0;
         prev    <= 1'b0;
      end else begin
         prev <= lvl;
         flag <= edge_hit | (flag & ~clr);
         if (wr_sel) begin
            out_val <= wdata[B_OUT];
            lo_en   <= wdata[B_LO_EN];
            hi_en   <= wdata[B_HI_EN];
            in_en   <= wdata[B_IN_EN];
            pin_en  <= wdata[B_PIN_EN];
            mode    <= trig_mode_e'(wdata[B_MODE_H:B_MODE_L]);
         end
      end
   end

   assign in_value = pin_en & in_en & lvl;
   assign pad_out  = out_val;
   assign pad_oe   = pin_en & (out_val ? hi_en : lo_en);
   assign irq      = pin_en & ((edge_mode & flag) | level_hit);

   always_comb begin
      word                     = '0;
      word[B_OUT]              = out_val;
      word[B_IN]               = in_value;
      word[B_LO_EN]            = lo_en;
      word[B_HI_EN]            = hi_en;
      word[B_IN_EN]            = in_en;
      word[B_MODE_H:B_MODE_L]  = mode;
      word[B_FLAG]             = flag;
      word[B_PIN_EN]           = pin_en;
   end

   // R9: a disabled pin neither drives nor interrupts
   p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |-> (!pad_oe && !irq && !in_value));
   // R8: none and reserved modes stay silent
   p_reserved_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRIG_NONE || mode == TRIG_RSV6 || mode == TRIG_RSV7) |-> !irq);
   // R6: the flag holds until a clear is written
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   // R6: a clear with no competing edge drops the flag
   p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_hit) |=> !flag);
   // R11: a same-cycle edge beats the clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && edge_hit) |=> flag);
   // R7: level modes never touch the flag
   p_level_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !edge_mode) |=> !flag);
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = $clog2(NUM_PINS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pin_irq,
   output logic                irq
);
   localparam int unsigned SUM_W = (NUM_PINS < WORD_W) ? NUM_PINS : WORD_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
         $error("gpio_bank: NUM_PINS must be 1..64");
      end
      if ((2 ** ADDR_W) < (NUM_PINS + 1)) begin : g_bad_addr
         $error("gpio_bank: ADDR_W too narrow for pins plus summary word");
      end
   endgenerate

   logic [NUM_PINS-1:0] lvl_sync, in_vals;
   logic [WORD_W-1:0]   words [NUM_PINS];
   logic [WORD_W-1:0]   summary;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (lvl_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (reg_we && (reg_addr == ADDR_W'(p))),
            .wdata   (reg_wdata),
            .lvl     (lvl_sync[p]),
            .word    (words[p]),
            .in_value(in_vals[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .irq     (pin_irq[p])
         );
      end
      if (SUM_W < WORD_W) begin : g_sum_pad
         assign summary = {{(WORD_W - SUM_W){1'b0}}, in_vals[SUM_W-1:0]};
      end else begin : g_sum_full
         assign summary = in_vals[WORD_W-1:0];
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++)
         if (reg_addr == ADDR_W'(i)) reg_rdata = words[i];
      if (reg_addr == ADDR_W'(NUM_PINS)) reg_rdata = summary;
   end

   assign irq = |pin_irq;

   // R10: the combined line is high only when some pin requests
   p_irq_combined_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ($countones(pin_irq) != 0));
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
   localparam int N  = 8;
   localparam int AW = 4;
   localparam logic [31:0] WMASK = 32'h8700_0071;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe, pin_irq;
   logic          irq;

   int checks = 0;
   int fails  = 0;

   // model state
   logic [31:0]  m_cfg [N];
   logic [N-1:0] m_s1, m_s2, m_prev, m_flag;

   always #2 clk = ~clk;

   gpio_bank #(.NUM_PINS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pin_irq(pin_irq), .irq(irq)
   );

   function automatic logic [31:0] cfg(input logic en, input logic [2:0] md,
      input logic ie, input logic hi, input logic lo, input logic ov);
      return {en, 3'b0, 1'b0, md, 17'b0, ie, hi, lo, 3'b0, ov};
   endfunction

   function automatic logic m_inval(input int i);
      return m_cfg[i][31] & m_cfg[i][6] & m_s2[i];
   endfunction
   function automatic logic m_oe(input int i);
      return m_cfg[i][31] & (m_cfg[i][0] ? m_cfg[i][5] : m_cfg[i][4]);
   endfunction
   function automatic logic m_irq(input int i);
      logic [2:0] md = m_cfg[i][26:24];
      logic e = (md >= 3'd1 && md <= 3'd3) & m_flag[i];
      logic l = (md == 3'd4 & ~m_s2[i]) | (md == 3'd5 & m_s2[i]);
      return m_cfg[i][31] & (e | l);
   endfunction
   function automatic logic [31:0] m_rdata(input logic [AW-1:0] a);
      logic [31:0] r = '0;
      if (int'(a) < N) begin
         r = m_cfg[a] | (32'(m_inval(int'(a))) << 1) | (32'(m_flag[a]) << 27);
      end else if (int'(a) == N) begin
         for (int i = 0; i < N; i++) r[i] = m_inval(i);
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) m_cfg[i] = 32'h1;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0;
   endtask

   task automatic model_clock();
      for (int i = 0; i < N; i++) begin
         logic [2:0] md = m_cfg[i][26:24];
         logic r = m_s2[i] & ~m_prev[i];
         logic f = ~m_s2[i] & m_prev[i];
         logic hit = m_cfg[i][31] & ((md == 3'd1 & r) | (md == 3'd2 & f) | (md == 3'd3 & (r | f)));
         logic cl = reg_we && (int'(reg_addr) == i) && reg_wdata[27];
         m_flag[i] = hit | (m_flag[i] & ~cl);
         if (reg_we && int'(reg_addr) == i) m_cfg[i] = reg_wdata & WMASK;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
   endtask

   task automatic compare_all();
      chk("R3 pad_oe", 32'(pad_oe), 32'(gen_oe()));
      chk("R3 pad_out", 32'(pad_out), 32'(gen_out()));
      chk("R6 pin_irq", 32'(pin_irq), 32'(gen_irq()));
      chk("R10 irq", 32'(irq), 32'(|gen_irq()));
      chk("R2 rdata", reg_rdata, m_rdata(reg_addr));
   endtask
   function automatic logic [N-1:0] gen_oe();
      for (int i = 0; i < N; i++) gen_oe[i] = m_oe(i);
   endfunction
   function automatic logic [N-1:0] gen_out();
      for (int i = 0; i < N; i++) gen_out[i] = m_cfg[i][0];
   endfunction
   function automatic logic [N-1:0] gen_irq();
      for (int i = 0; i < N; i++) gen_irq[i] = m_irq(i);
   endfunction

   // inputs set after a falling edge, one rising edge, sample at next falling edge
   task automatic step(input logic [AW-1:0] a, input logic we, input logic [31:0] wd,
                       input logic [N-1:0] pad);
      reg_addr = a; reg_we = we; reg_wdata = wd; pad_in = pad;
      @(posedge clk);
      model_clock();
      @(negedge clk);
      reg_we = 1'b0;
      compare_all();
   endtask

   task automatic rd(input logic [AW-1:0] a);
      reg_addr = a; reg_we = 1'b0;
      #0.1;
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [N-1:0] pad;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(0);    chk("R1 pin0 word", reg_rdata, 32'h0000_0001);
      rd(N-1);  chk("R1 last pin word", reg_rdata, 32'h0000_0001);
      rd(AW'(N)); chk("R1 summary", reg_rdata, 32'h0);
      chk("R1 pad_oe", 32'(pad_oe), 32'h0);

      // R2: field layout, all-ones write with pad low
      step(0, 1, 32'hFFFF_FFFF, '0);
      rd(0); chk("R2 writable mask", reg_rdata, 32'h8700_0071);
      step(AW'(N), 1, 32'hFFFF_FFFF, '0);
      rd(AW'(N)); chk("R2 summary write ignored", reg_rdata, 32'h0);
      rd(AW'(N+3)); chk("R2 out of range", reg_rdata, 32'h0);

      // R3: drive rules on pin 1
      step(1, 1, cfg(1, 0, 0, 0, 1, 0), '0);
      chk("R3 low driven", 32'({pad_oe[1], pad_out[1]}), 32'b10);
      step(1, 1, cfg(1, 0, 0, 0, 1, 1), '0);
      chk("R3 high tristated", 32'(pad_oe[1]), 32'd0);
      step(1, 1, cfg(1, 0, 0, 1, 0, 1), '0);
      chk("R3 high driven", 32'({pad_oe[1], pad_out[1]}), 32'b11);

      // R4 / R5: input gating and summary
      step(2, 1, cfg(1, 0, 1, 0, 0, 0), '0);
      step(0, 0, 0, 8'h04);
      rd(2); chk("R4 not yet after one edge", 32'(reg_rdata[1]), 32'd0);
      step(0, 0, 0, 8'h04);
      rd(2); chk("R4 visible after two edges", 32'(reg_rdata[1]), 32'd1);
      rd(AW'(N)); chk("R5 summary bit2", reg_rdata, 32'h0000_0004);
      step(2, 1, cfg(1, 0, 0, 0, 0, 0), 8'h04);
      rd(2); chk("R4 gated by input enable", 32'(reg_rdata[1]), 32'd0);

      // R6: rising edge on pin 3
      step(3, 1, cfg(1, 3'd1, 0, 0, 0, 0), 8'h00);
      step(0, 0, 0, 8'h08);
      step(0, 0, 0, 8'h08);
      chk("R6 flag not before third edge", 32'(pin_irq[3]), 32'd0);
      step(0, 0, 0, 8'h08);
      chk("R6 flag on third edge", 32'(pin_irq[3]), 32'd1);
      step(3, 1, cfg(1, 3'd1, 0, 0, 0, 0), 8'h08);
      chk("R6 write zero keeps flag", 32'(pin_irq[3]), 32'd1);
      step(3, 1, cfg(1, 3'd1, 0, 0, 0, 0) | 32'h0800_0000, 8'h08);
      chk("R6 write one clears", 32'(pin_irq[3]), 32'd0);
      chk("R10 irq low", 32'(irq), 32'd0);

      // R11: edge and clear in the same cycle (falling mode)
      step(3, 1, cfg(1, 3'd2, 0, 0, 0, 0), 8'h00);
      step(0, 0, 0, 8'h00);
      step(3, 1, cfg(1, 3'd2, 0, 0, 0, 0) | 32'h0800_0000, 8'h00);
      chk("R11 set beats clear", 32'(pin_irq[3]), 32'd1);
      chk("R10 irq high", 32'(irq), 32'd1);
      step(3, 1, cfg(1, 3'd0, 0, 0, 0, 0) | 32'h0800_0000, 8'h00);

      // R7: level high on pin 4
      step(4, 1, cfg(1, 3'd5, 0, 0, 0, 0), 8'h00);
      step(0, 0, 0, 8'h10);
      chk("R7 level not after one edge", 32'(pin_irq[4]), 32'd0);
      step(0, 0, 0, 8'h10);
      chk("R7 level high", 32'(pin_irq[4]), 32'd1);
      rd(4); chk("R7 flag unused", 32'(reg_rdata[27]), 32'd0);
      step(4, 1, cfg(1, 3'd4, 0, 0, 0, 0), 8'h10);
      chk("R7 level low mode off", 32'(pin_irq[4]), 32'd0);

      // R8: reserved mode with toggles
      step(5, 1, cfg(1, 3'd6, 0, 0, 0, 0), 8'h00);
      for (int k = 0; k < 6; k++) step(0, 0, 0, (k % 2) ? 8'h20 : 8'h00);
      chk("R8 reserved silent", 32'(pin_irq[5]), 32'd0);

      // R9: disabled pin with edge mode and toggles
      step(6, 1, cfg(0, 3'd3, 1, 1, 1, 1), 8'h00);
      for (int k = 0; k < 5; k++) step(0, 0, 0, (k % 2) ? 8'h00 : 8'h40);
      rd(6); chk("R9 disabled word", reg_rdata, 32'h0300_0071);
      chk("R9 disabled quiet", 32'({pad_oe[6], pin_irq[6]}), 32'd0);

      // random phase against the model
      pad = '0;
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] wd = $urandom();
         if ($urandom_range(3) != 0) wd[31] = 1'b1;
         if ($urandom_range(7) == 0) pad[$urandom_range(N-1)] ^= 1'b1;
         step(AW'($urandom_range(15)), ($urandom_range(9) < 3), wd, pad);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule